// File: doc/BRIEF.md
# Progressive to Interlaced Line Dropper

This block takes a progressive video stream and turns it into an interlaced one. It keeps every other line of each input frame and drops the rest. A frame that keeps the even-numbered lines becomes a top field (F0). A frame that keeps the odd-numbered lines becomes a bottom field (F1). Successive progressive frames alternate between the two, so one field leaves the block for every frame that enters it.

The stream is packet based and uses ready/valid handshaking with start-of-packet and end-of-packet markers. The first beat of each packet carries a type code. A control packet has a single payload beat that holds the frame width, the frame height and a 4-bit interlace code. The block rewrites that payload so that it describes the field it will emit. Several things can change the field order:

- A new resolution restarts the order at a configurable first field.
- An optional override lets the interlace code force the next field.
- A parameter decides whether input that is already interlaced is forwarded unchanged or discarded.
- A run-time enable switches interlacing off, so progressive frames pass through untouched.

Top module: `pi_line_dropper`

## Requirements
- R1: In an F0 field only input lines 0, 2, 4, … of the video packet are forwarded. In an F1 field only lines 1, 3, 5, … are forwarded. The video header beat (start-of-packet, type 0x0 in bits [3:0]) is always forwarded, and pixel beats keep their order and values.
- R2: With the enable high and no override, consecutive progressive frames of the same resolution produce alternating F0 and F1 fields.
- R3: Width and height are taken from every control payload beat: width in bits [WW-1:0], height in bits [WW+HW-1:WW]. The pixel counter wraps at the width and the line counter restarts with each video packet.
- R4: In field mode the control payload is rewritten as follows:
  - the height becomes ceil(h/2) for F0 and floor(h/2) for F1;
  - the interlace code in bits [WW+HW+3:WW+HW] becomes 0b1000 for F0 and 0b1001 for F1;
  - the width and all other bits are unchanged.
- R5: The first field after reset, and the first field after any change of width or height, is F1 when START_F1 is 1 and F0 otherwise.
- R6: An interlace code with bit 3 set marks input that is already interlaced. With PASS_IL=1 the control and video packets are forwarded unchanged. With PASS_IL=0 both packets are consumed and nothing is emitted.
- R7: While `ilace_en` is low, control and video packets pass through unchanged. The enable is sampled when a control header (type 0xF) is accepted, or at a video header that has no preceding control packet, so toggling it in the middle of a frame has no effect on that frame.
- R8: With OVERRIDE=1, interlace code 0b0000 forces the next field to be F0 and code 0b0001 forces it to be F1. Alternation continues from the forced field. With OVERRIDE=0 these codes are treated as ordinary progressive codes.
- R9: Beats of dropped lines and of discarded packets are accepted with `in_ready` high and produce no output. Forwarded beats honour `out_ready` and hold their values while stalled. Every output packet begins with start-of-packet and ends with end-of-packet. In field mode, end-of-packet is placed on the last pixel of the last kept line.
- R10: A video packet that arrives without a preceding control packet reuses the last known resolution. It continues the field alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ilace_en | input | 1 | Run-time interlacing enable |
| in_data | input | DW | Input beat data |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_ready | output | 1 | Block can accept an input beat |
| out_data | output | DW | Output beat data |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_ready | input | 1 | Downstream can accept an output beat |

## Verification
There are no registers on the data path. A forwarded beat appears on the output in the same cycle that its input beat is presented. The one exception is the control header: it is held inside the block and appears in the cycle in which the payload beat is presented. Field parity, the output height and the end-of-packet position are all fixed by state that is updated at the handshake edge before the affected beat. A frame's result is therefore complete once its last input beat is accepted. The bench records every output handshake at the falling edge, when `out_valid` and `out_ready` have settled. It then waits a fixed drain window after each frame and compares the recorded beat stream, in order, against a stream built from the requirements.

// File: rtl/pi_line_dropper.sv
module pi_line_dropper #(
  parameter int DW = 32,
  parameter int WW = 12,
  parameter int HW = 12,
  parameter bit START_F1 = 1'b0,
  parameter bit PASS_IL = 1'b1,
  parameter bit OVERRIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ilace_en,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_sop,
  output logic          out_eop,
  input  logic          out_ready
);
  // DW must be at least WW + HW + 4.
  localparam int CODE_LSB = WW + HW;
  localparam logic [3:0] T_CTL = 4'hF;
  localparam logic [3:0] T_VID = 4'h0;

  typedef enum logic [2:0] {S_IDLE, S_HELD, S_CPAY, S_PASS, S_DROP, S_FIELD} st_t;
  typedef enum logic [1:0] {M_PASS, M_DROP, M_FIELD} mode_t;

  st_t st;
  logic en_q, res_known, last_il, next_par, plan_vld, plan_par, fpar, done;
  mode_t plan_mode;
  logic [WW-1:0] cur_w, pix;
  logic [HW-1:0] cur_h, line, last_keep;

  logic [WW-1:0] pw;
  logic [HW-1:0] ph, hout, hm1, lk;
  logic [HW:0] ph_up;
  logic [3:0] pcode, in_type;
  logic res_chg, d_par, v_par, keep, at_last, acc, commit;
  mode_t d_mode, v_mode;

  assign pw      = in_data[WW-1:0];
  assign ph      = in_data[WW +: HW];
  assign pcode   = in_data[CODE_LSB +: 4];
  assign in_type = in_data[3:0];
  assign res_chg = !res_known || (pw != cur_w) || (ph != cur_h);
  assign ph_up   = {1'b0, ph} + 1'b1;
  assign hout    = d_par ? (ph >> 1) : ph_up[HW:1];
  assign hm1     = cur_h - 1'b1;
  assign lk      = (hm1[0] == v_par) ? hm1 : hm1 - 1'b1;
  assign keep    = !done && (line[0] == fpar);
  assign at_last = (line == last_keep) && (pix == cur_w - 1'b1);
  assign acc     = in_valid && in_ready;
  assign commit  = acc && ((st == S_CPAY) || (st == S_HELD));

  always_comb begin
    if (!en_q) d_mode = M_PASS;
    else if (pcode[3]) d_mode = PASS_IL ? M_PASS : M_DROP;
    else d_mode = M_FIELD;
    if (OVERRIDE && pcode == 4'b0000) d_par = 1'b0;
    else if (OVERRIDE && pcode == 4'b0001) d_par = 1'b1;
    else if (res_chg) d_par = START_F1;
    else d_par = next_par;
  end

  always_comb begin
    if (plan_vld) begin
      v_mode = plan_mode;
      v_par  = plan_par;
    end else begin
      v_par = next_par;
      if (!ilace_en || !res_known) v_mode = M_PASS;
      else if (last_il) v_mode = PASS_IL ? M_PASS : M_DROP;
      else v_mode = M_FIELD;
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = in_data;
    out_sop   = in_sop;
    out_eop   = in_eop;
    in_ready  = 1'b1;
    case (st)
      S_IDLE:
        if (in_sop && in_type != T_CTL && !(in_type == T_VID && v_mode == M_DROP)) begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      S_HELD:
        if (in_valid && d_mode != M_DROP) begin
          out_valid = 1'b1;
          out_data  = '0;
          out_data[3:0] = T_CTL;
          out_sop   = 1'b1;
          out_eop   = 1'b0;
          in_ready  = 1'b0;
        end
      S_CPAY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_sop   = 1'b0;
        if (d_mode == M_FIELD) begin
          out_data[CODE_LSB +: 4] = {3'b100, d_par};
          out_data[WW +: HW] = hout;
        end
      end
      S_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
      end
      S_FIELD:
        if (keep) begin
          out_valid = in_valid;
          in_ready  = out_ready;
          out_sop   = 1'b0;
          out_eop   = in_eop || at_last;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      en_q      <= 1'b0;
      res_known <= 1'b0;
      last_il   <= 1'b0;
      next_par  <= START_F1;
      plan_vld  <= 1'b0;
      plan_mode <= M_PASS;
      plan_par  <= 1'b0;
      fpar      <= 1'b0;
      done      <= 1'b0;
      cur_w     <= '0;
      cur_h     <= '0;
      pix       <= '0;
      line      <= '0;
      last_keep <= '0;
    end else begin
      if (commit) begin
        cur_w     <= pw;
        cur_h     <= ph;
        res_known <= 1'b1;
        last_il   <= pcode[3];
        plan_vld  <= 1'b1;
        plan_mode <= d_mode;
        plan_par  <= d_par;
        if (d_mode != M_FIELD && res_chg) next_par <= START_F1;
      end
      case (st)
        S_IDLE:
          if (acc && in_sop) begin
            if (in_type == T_CTL) begin
              en_q <= ilace_en;
              st   <= in_eop ? S_IDLE : S_HELD;
            end else if (in_type == T_VID) begin
              plan_vld <= 1'b0;
              if (v_mode == M_FIELD) begin
                fpar      <= v_par;
                next_par  <= !v_par;
                pix       <= '0;
                line      <= '0;
                done      <= 1'b0;
                last_keep <= lk;
                st <= in_eop ? S_IDLE : S_FIELD;
              end else if (v_mode == M_DROP) begin
                st <= in_eop ? S_IDLE : S_DROP;
              end else begin
                st <= in_eop ? S_IDLE : S_PASS;
              end
            end else begin
              st <= in_eop ? S_IDLE : S_PASS;
            end
          end
        S_HELD:
          if (acc) st <= in_eop ? S_IDLE : S_DROP;
          else if (in_valid && out_ready) st <= S_CPAY;
        S_CPAY:
          if (acc) st <= in_eop ? S_IDLE : S_PASS;
        S_PASS, S_DROP:
          if (acc && in_eop) st <= S_IDLE;
        S_FIELD:
          if (acc) begin
            if (in_eop) st <= S_IDLE;
            if (keep && at_last) done <= 1'b1;
            if (pix == cur_w - 1'b1) begin
              pix  <= '0;
              line <= line + 1'b1;
            end else begin
              pix <= pix + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic out_open;
  always_ff @(posedge clk) begin
    if (rst) out_open <= 1'b0;
    else if (out_valid && out_ready) out_open <= !out_eop;
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  a_r9_framing: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> !out_open);
  a_r9_drop_sink: assert property (@(posedge clk) disable iff (rst)
    st == S_DROP |-> in_ready && !out_valid);
  a_r3_pix_bound: assert property (@(posedge clk) disable iff (rst)
    st == S_FIELD |-> pix < cur_w);
  a_r1_kept_parity: assert property (@(posedge clk) disable iff (rst)
    st == S_FIELD && out_valid |-> line[0] == fpar);
  a_r7_transparent: assert property (@(posedge clk) disable iff (rst)
    st == S_PASS |-> out_data == in_data && out_valid == in_valid && in_ready == out_ready);
endmodule

// File: tb/pi_line_dropper_tb.sv
module pi_line_dropper_tb;
  localparam int DW = 32, WW = 12, HW = 12;
  logic clk = 1'b0, rst = 1'b1, en = 1'b1, sel = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
  logic r0, v0, s0, e0, r1, v1, s1, e1;
  logic [DW-1:0] d0, d1;
  int checks = 0, fails = 0;
  logic [33:0] got[$], exq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pi_line_dropper #(.DW(DW), .WW(WW), .HW(HW)) u_dut (
    .clk(clk), .rst(rst), .ilace_en(en), .in_data(in_data), .in_valid(in_valid && !sel),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(r0), .out_data(d0), .out_valid(v0),
    .out_sop(s0), .out_eop(e0), .out_ready(out_ready));

  pi_line_dropper #(.DW(DW), .WW(WW), .HW(HW), .START_F1(1'b1), .PASS_IL(1'b0), .OVERRIDE(1'b0)) u_dut2 (
    .clk(clk), .rst(rst), .ilace_en(en), .in_data(in_data), .in_valid(in_valid && sel),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(r1), .out_data(d1), .out_valid(v1),
    .out_sop(s1), .out_eop(e1), .out_ready(out_ready));

  // {dut, en, noctl, flip, code[4], w[12], h[12], expect[2]}; expect 0=F0 1=F1 2=pass 3=drop
  localparam logic [33:0] TBL [22] = '{
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd0}, // R5 first field after reset
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd1}, // R2
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd0}, // R2
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd3,12'd5,2'd0}, // R3 R5 new resolution, R4 odd height
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd3,12'd5,2'd1}, // R4 floor height
    {1'b0,1'b1,1'b0,1'b0,4'd0,12'd3,12'd5,2'd0}, // R8 forced F0
    {1'b0,1'b1,1'b0,1'b0,4'd0,12'd3,12'd5,2'd0}, // R8
    {1'b0,1'b1,1'b0,1'b0,4'd1,12'd3,12'd5,2'd1}, // R8 forced F1
    {1'b0,1'b1,1'b0,1'b0,4'd1,12'd3,12'd5,2'd1}, // R8
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd3,12'd5,2'd0}, // R8 alternation resumes
    {1'b0,1'b1,1'b0,1'b0,4'd8,12'd3,12'd5,2'd2}, // R6 interlaced forwarded
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd3,12'd5,2'd1}, // R2
    {1'b0,1'b0,1'b0,1'b0,4'd2,12'd3,12'd5,2'd2}, // R7 bypass
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd3,12'd5,2'd0}, // R2
    {1'b0,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd0}, // R5 resolution change restart
    {1'b0,1'b1,1'b1,1'b0,4'd2,12'd4,12'd4,2'd1}, // R10 video without control
    {1'b0,1'b1,1'b0,1'b1,4'd2,12'd4,12'd4,2'd0}, // R7 enable dropped mid frame
    {1'b0,1'b0,1'b0,1'b0,4'd2,12'd4,12'd4,2'd2}, // R7
    {1'b1,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd1}, // R5 START_F1=1
    {1'b1,1'b1,1'b0,1'b0,4'd0,12'd4,12'd4,2'd0}, // R8 override off
    {1'b1,1'b1,1'b0,1'b0,4'd8,12'd4,12'd4,2'd3}, // R6 interlaced discarded
    {1'b1,1'b1,1'b0,1'b0,4'd2,12'd4,12'd4,2'd1}  // R6 R9 order unaffected by discard
  };

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = lfsr[1:0] != 2'b00;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!sel && v0 && out_ready) got.push_back({s0, e0, d0});
      if (sel && v1 && out_ready) got.push_back({s1, e1, d1});
    end
  end

  function automatic logic [DW-1:0] pixv(int l, int p);
    return 32'hA000_0000 | DW'(l << 8) | DW'(p);
  endfunction

  task automatic send_beat(input logic [DW-1:0] d, input logic s, input logic e);
    logic ok;
    in_data = d; in_sop = s; in_eop = e; in_valid = 1'b1;
    do begin
      @(negedge clk); ok = sel ? r1 : r0;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send_frame(input logic [3:0] code, input int w, input int h, input logic noctl, input logic flip);
    if (!noctl) begin
      send_beat(32'hF, 1'b1, 1'b0);
      send_beat({4'h0, code, HW'(h), WW'(w)}, 1'b0, 1'b1);
    end
    if (flip) en = ~en;
    send_beat('0, 1'b1, 1'b0);
    for (int l = 0; l < h; l++)
      for (int p = 0; p < w; p++)
        send_beat(pixv(l, p), 1'b0, (l == h - 1) && (p == w - 1));
  endtask

  task automatic build_exp(input logic [3:0] code, input int w, input int h, input logic noctl, input logic [1:0] ex);
    int lk;
    exq.delete();
    if (ex == 2'd3) return;
    if (ex == 2'd2) begin
      if (!noctl) begin
        exq.push_back({2'b10, 32'hF});
        exq.push_back({2'b01, 4'h0, code, HW'(h), WW'(w)});
      end
      exq.push_back({2'b10, 32'h0});
      for (int l = 0; l < h; l++)
        for (int p = 0; p < w; p++)
          exq.push_back({1'b0, (l == h - 1) && (p == w - 1), pixv(l, p)});
      return;
    end
    if (!noctl) begin
      exq.push_back({2'b10, 32'hF});
      exq.push_back({2'b01, 4'h0, 3'b100, ex[0], HW'(ex[0] ? h / 2 : (h + 1) / 2), WW'(w)});
    end
    exq.push_back({2'b10, 32'h0});
    lk = ((h - 1) % 2 == int'(ex[0])) ? h - 1 : h - 2;
    for (int l = int'(ex[0]); l < h; l += 2)
      for (int p = 0; p < w; p++)
        exq.push_back({1'b0, (l == lk) && (p == w - 1), pixv(l, p)});
  endtask

  task automatic check(input logic c, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] ex);
    return (ex == 2'd3) ? "R6" : (ex == 2'd2) ? "R7" : "R1";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, checks + 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    check(v0 === 1'b0 && v1 === 1'b0, "R9 reset out_valid", {33'b0, v0}, 34'd0);
    rst = 1'b0;
    @(negedge clk);
    check(v0 === 1'b0, "R9 idle out_valid", {33'b0, v0}, 34'd0);
    check(r0 === 1'b1 && r1 === 1'b1, "R9 idle in_ready", {32'b0, r0, r1}, 34'd3);
    @(posedge clk); #1;
    for (int i = 0; i < 22; i++) begin
      logic [33:0] e;
      string tg;
      e = TBL[i];
      sel = e[33];
      en = e[32];
      tg = tag_of(e[1:0]);
      got.delete();
      build_exp(e[29:26], int'(e[25:14]), int'(e[13:2]), e[31], e[1:0]);
      send_frame(e[29:26], int'(e[25:14]), int'(e[13:2]), e[31], e[30]);
      repeat (20) @(posedge clk); #1;
      check(got.size() == exq.size(), $sformatf("R9 beat count frame %0d", i),
            34'(got.size()), 34'(exq.size()));
      for (int k = 0; k < exq.size(); k++) begin
        logic [33:0] a;
        a = (k < got.size()) ? got[k] : 34'h3_FFFF_FFFF;
        // field/code/height beats cover R2 R4 R5 R8 R10 through the table expectations
        check(a === exq[k], $sformatf("%s frame %0d beat %0d", (k == 1 && !e[31]) ? "R4" : tg, i, k), a, exq[k]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule